// File: doc/BRIEF.md
# Codec Power Sequencer

This block holds the digital side of a multichannel audio codec in a safe state while the chip is powered down and then brings it up again. An active-low chip power-down input is brought into the system clock domain. While that input is low, the control registers and both digital filters are held in reset, the serial ADC output is forced to zero, the DAC paths are muted at midscale and the zero-detect flags are held low. After the input is released, each converter path runs its own initialization window. The length of each window is a number of frame (sample-rate) strobes.

Two register bits can power down the ADC path and the DAC path on their own. These per-path controls leave the register contents intact, and they drive the zero flags to the opposite level from the one used during chip power-down. Leaving a per-path power-down restarts only that path's window. The block also raises an external-mute request that covers the output transients expected at power-down and around the end of the analog settling. It gives a ready indication for each path.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `pdn_n` is low, `ctrl_reg_rst`, `adc_filt_rst` and `dac_filt_rst` are 1, `adc_sdo_zero`, `dac_mute_req` and `ext_mute_req` are 1, `adc_ready` and `dac_ready` are 0, and every bit of `zero_flag` is 0. These levels appear without waiting for a clock edge, and frame strobes received in this state are not counted.
- R2: After `pdn_n` rises, the three reset outputs fall on the second rising clock edge that follows.
- R3: After the chip wakes, `adc_sdo_zero` stays 1 until the 522nd frame strobe has been counted, and falls in the cycle after that strobe.
- R4: After the chip wakes, `dac_mute_req` stays 1 until the 516th frame strobe has been counted, and falls in the cycle after that strobe.
- R5: After the chip wakes, every `zero_flag` bit stays 0 until 11 frame strobes have been counted. After that, bit i follows `zero_det_in[i]`.
- R6: With `adc_pwr_en` = 0, `adc_sdo_zero` is 1 and `adc_ready` is 0 at once, `ctrl_reg_rst` stays 0, and the DAC outputs are unchanged.
- R7: With `dac_pwr_en` = 0 and the wake blanking over, `dac_mute_req` is 1, every `zero_flag` bit is 1 whatever `zero_det_in` is, and `ctrl_reg_rst` stays 0.
- R8: `ext_mute_req` is 1 while powered down. After a wake it is 0 until 512 frame strobes have been counted, then 1 for the next 4 frame strobes. It is 0 from the 516th strobe on.
- R9: If `pdn_n` falls before a window is complete, every window restarts from zero on the next wake.
- R10: When `adc_pwr_en` or `dac_pwr_en` goes from 0 to 1, only that path's window restarts from zero. The other path's outputs do not change.
- R11: `adc_ready` (or `dac_ready`) is 1 exactly when the chip is awake, the path's enable is 1 and its window is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Chip power-down, active low, asynchronous |
| adc_pwr_en | input | 1 | ADC path enable register bit (0 powers the path down) |
| dac_pwr_en | input | 1 | DAC path enable register bit (0 powers the paths down) |
| frame_stb | input | 1 | One-cycle strobe, once per frame |
| zero_det_in | input | NZF | Raw zero-detect results from the DAC datapath |
| ctrl_reg_rst | output | 1 | Control register reset |
| adc_filt_rst | output | 1 | ADC digital filter reset |
| dac_filt_rst | output | 1 | DAC digital filter reset |
| adc_sdo_zero | output | 1 | Forces the serial ADC output to zero data |
| dac_mute_req | output | 1 | Holds the DAC outputs at midscale |
| ext_mute_req | output | 1 | Request for external analog muting |
| adc_ready | output | 1 | ADC path is delivering real data |
| dac_ready | output | 1 | DAC path is live |
| zero_flag | output | NZF | Zero-detect flag outputs |

## Verification
The main coincidence is the shared wake count: the external-mute window closes on the same frame strobe that completes the DAC window. The bench counts exactly 516 strobes after a wake. It then expects, at the same sample point, `ext_mute_req` to fall, `dac_mute_req` to fall and `dac_ready` to rise, while `adc_sdo_zero` is still held. A second coincidence is a per-path enable that drops on a clock where that path's window is already complete. The bench expects the gate and the ready bit to switch in that same cycle, with no one-cycle glimpse of live data.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   // larger of two elaboration-time integers
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwrseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   // asserted asynchronously, released after STAGES edges
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign q = chain[STAGES-1];

   assert_release_after_high_R2: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(q) |-> $past(arst_n));

endmodule

// File: rtl/pwrseq_window.sv
module pwrseq_window #(
   parameter int LIMIT = 16,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         hold,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         done
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("pwrseq_window: LIMIT must be positive");
   end

   localparam logic [W-1:0] TOP = W'(LIMIT);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                     cnt <= '0;
      else if (hold)                   cnt <= '0;
      else if (tick && (cnt != TOP))   cnt <= cnt + 1'b1;
   end

   assign done = (cnt == TOP);

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!arst_n)
      cnt <= TOP);

   assert_cnt_idle_R3: assert property (@(posedge clk) disable iff (!arst_n)
      (!hold && !tick) |=> (cnt == $past(cnt)));

   assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!arst_n)
      hold |=> (cnt == '0));

endmodule

// File: rtl/pwrseq_zflag.sv
module pwrseq_zflag #(
   parameter int NZF = 2
) (
   input  logic           awake,
   input  logic           blank_done,
   input  logic           dac_en,
   input  logic [NZF-1:0] zd_in,
   output logic [NZF-1:0] zflag
);

   for (genvar i = 0; i < NZF; i++) begin : g_ch
      always_comb begin
         if (!awake || !blank_done) zflag[i] = 1'b0;
         else if (!dac_en)          zflag[i] = 1'b1;
         else                       zflag[i] = zd_in[i];
      end
   end

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq #(
   parameter int NZF             = 2,
   parameter int SYNC_STAGES     = 2,
   parameter int ADC_INIT_FRAMES = 522,
   parameter int DAC_INIT_FRAMES = 516,
   parameter int ZF_HOLD_FRAMES  = 11,
   parameter int CLICK_FRAMES    = 512,
   parameter int MUTE_FRAMES     = 4
) (
   input  logic           clk,
   input  logic           pdn_n,
   input  logic           adc_pwr_en,
   input  logic           dac_pwr_en,
   input  logic           frame_stb,
   input  logic [NZF-1:0] zero_det_in,
   output logic           ctrl_reg_rst,
   output logic           adc_filt_rst,
   output logic           dac_filt_rst,
   output logic           adc_sdo_zero,
   output logic           dac_mute_req,
   output logic           ext_mute_req,
   output logic           adc_ready,
   output logic           dac_ready,
   output logic [NZF-1:0] zero_flag
);
   import pwrseq_pkg::*;

   localparam int WAKE_MAX = imax(ZF_HOLD_FRAMES, CLICK_FRAMES + MUTE_FRAMES);
   localparam int WAKE_W   = $clog2(WAKE_MAX + 1);
   localparam int ADC_W    = $clog2(ADC_INIT_FRAMES + 1);
   localparam int DAC_W    = $clog2(DAC_INIT_FRAMES + 1);

   if (NZF < 1) begin : g_bad_nzf
      $error("codec_pwr_seq: NZF must be at least 1");
   end
   if (MUTE_FRAMES < 1) begin : g_bad_mute
      $error("codec_pwr_seq: MUTE_FRAMES must be at least 1");
   end

   logic              awake;
   logic [WAKE_W-1:0] wake_cnt;
   logic              wake_full;
   logic [ADC_W-1:0]  adc_cnt;
   logic              adc_done;
   logic [DAC_W-1:0]  dac_cnt;
   logic              dac_done;
   logic              blank_done;
   logic              click_win;

   pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(pdn_n), .q(awake));

   pwrseq_window #(.LIMIT(WAKE_MAX)) u_wake (
      .clk(clk), .arst_n(pdn_n), .hold(!awake), .tick(frame_stb),
      .cnt(wake_cnt), .done(wake_full));

   pwrseq_window #(.LIMIT(ADC_INIT_FRAMES)) u_adc_win (
      .clk(clk), .arst_n(pdn_n), .hold(!awake || !adc_pwr_en), .tick(frame_stb),
      .cnt(adc_cnt), .done(adc_done));

   pwrseq_window #(.LIMIT(DAC_INIT_FRAMES)) u_dac_win (
      .clk(clk), .arst_n(pdn_n), .hold(!awake || !dac_pwr_en), .tick(frame_stb),
      .cnt(dac_cnt), .done(dac_done));

   assign blank_done = (wake_cnt >= WAKE_W'(ZF_HOLD_FRAMES));
   assign click_win  = (wake_cnt >= WAKE_W'(CLICK_FRAMES)) &&
                       (wake_cnt <  WAKE_W'(CLICK_FRAMES + MUTE_FRAMES));

   pwrseq_zflag #(.NZF(NZF)) u_zflag (
      .awake(awake), .blank_done(blank_done), .dac_en(dac_pwr_en),
      .zd_in(zero_det_in), .zflag(zero_flag));

   assign ctrl_reg_rst = !awake;
   assign adc_filt_rst = !awake;
   assign dac_filt_rst = !awake;
   assign adc_ready    = awake && adc_pwr_en && adc_done;
   assign dac_ready    = awake && dac_pwr_en && dac_done;
   assign adc_sdo_zero = !adc_ready;
   assign dac_mute_req = !dac_ready;
   assign ext_mute_req = !awake || click_win;

   assert_adc_ready_on_frame_R11: assert property (@(posedge clk) disable iff (!pdn_n)
      $rose(adc_ready) |-> $past(frame_stb));

   assert_dac_ready_on_frame_R11: assert property (@(posedge clk) disable iff (!pdn_n)
      $rose(dac_ready) |-> $past(frame_stb));

   assert_adc_gate_R3: assert property (@(posedge clk) disable iff (!pdn_n)
      (adc_cnt != ADC_W'(ADC_INIT_FRAMES)) |-> adc_sdo_zero);

   assert_dac_gate_R4: assert property (@(posedge clk) disable iff (!pdn_n)
      (dac_cnt != DAC_W'(DAC_INIT_FRAMES)) |-> dac_mute_req);

   assert_zf_low_after_wake_R5: assert property (@(posedge clk) disable iff (!pdn_n)
      $rose(awake) |=> (zero_flag == '0));

   assert_click_after_frame_R8: assert property (@(posedge clk) disable iff (!pdn_n)
      ($rose(ext_mute_req) && awake) |-> $past(frame_stb));

   assert_wake_full_quiet_R8: assert property (@(posedge clk) disable iff (!pdn_n)
      wake_full |-> !ext_mute_req);

endmodule

// File: tb/codec_pwr_seq_tb.sv
module codec_pwr_seq_tb;

   logic       clk = 1'b0;
   logic       pdn_n = 1'b0;
   logic       adc_pwr_en = 1'b1;
   logic       dac_pwr_en = 1'b1;
   logic       frame_stb = 1'b0;
   logic [1:0] zero_det_in = 2'b11;
   logic       ctrl_reg_rst, adc_filt_rst, dac_filt_rst;
   logic       adc_sdo_zero, dac_mute_req, ext_mute_req, adc_ready, dac_ready;
   logic [1:0] zero_flag;

   always #5 clk = ~clk;

   codec_pwr_seq u_dut (
      .clk(clk), .pdn_n(pdn_n), .adc_pwr_en(adc_pwr_en), .dac_pwr_en(dac_pwr_en),
      .frame_stb(frame_stb), .zero_det_in(zero_det_in),
      .ctrl_reg_rst(ctrl_reg_rst), .adc_filt_rst(adc_filt_rst), .dac_filt_rst(dac_filt_rst),
      .adc_sdo_zero(adc_sdo_zero), .dac_mute_req(dac_mute_req), .ext_mute_req(ext_mute_req),
      .adc_ready(adc_ready), .dac_ready(dac_ready), .zero_flag(zero_flag));

   // observation vector: {rst3, adc_zero, dac_mute, ext, adc_rdy, dac_rdy, zf[1:0]}
   localparam logic [9:0] M_RST  = 10'b1110000000;
   localparam logic [9:0] M_AZ   = 10'b0001000000;
   localparam logic [9:0] M_DM   = 10'b0000100000;
   localparam logic [9:0] M_EXT  = 10'b0000010000;
   localparam logic [9:0] M_AR   = 10'b0000001000;
   localparam logic [9:0] M_DR   = 10'b0000000100;
   localparam logic [9:0] M_ZF   = 10'b0000000011;
   localparam logic [9:0] M_ALL  = 10'b1111111111;
   localparam logic [9:0] V_DOWN = 10'b1111110000;

   typedef struct {
      string      req;
      logic [9:0] exp;
      logic [9:0] mask;
   } item_t;

   item_t q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   function automatic logic [9:0] obs();
      return {ctrl_reg_rst, adc_filt_rst, dac_filt_rst, adc_sdo_zero, dac_mute_req,
              ext_mute_req, adc_ready, dac_ready, zero_flag};
   endfunction

   // driver side: queue an expectation for the current sample point
   task automatic expect_out(input string req, input logic [9:0] exp, input logic [9:0] mask);
      item_t it;
      it.req = req; it.exp = exp; it.mask = mask;
      q.push_back(it);
   endtask

   // monitor: compare shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [9:0] act;
            it  = q.pop_front();
            act = obs() & it.mask;
            n_run++;
            if (act !== (it.exp & it.mask)) begin
               n_fail++;
               $display("FAIL %s actual=%b expected=%b", it.req, act, it.exp & it.mask);
            end
         end
      end
   end

   task automatic frames(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); frame_stb = 1'b1;
         @(negedge clk); frame_stb = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic wake();
      @(negedge clk); pdn_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: powered-down state, strobes ignored
      repeat (2) @(negedge clk);
      expect_out("R1", V_DOWN, M_ALL);
      frames(3);
      expect_out("R1", V_DOWN, M_ALL);

      // R2: two-edge release
      @(negedge clk); pdn_n = 1'b1;
      expect_out("R2", M_RST, M_RST);
      @(negedge clk);
      expect_out("R2", M_RST, M_RST);
      @(negedge clk);
      expect_out("R2", 10'b0, M_RST);
      @(negedge clk);

      // R5: zero-flag blanking then follow
      zero_det_in = 2'b10;
      frames(10);
      expect_out("R5", 10'b0, M_ZF);
      frames(1);
      expect_out("R5", 10'b10, M_ZF);
      @(negedge clk); zero_det_in = 2'b01;
      expect_out("R5", 10'b01, M_ZF);

      // R8/R4/R3: click window, DAC and ADC windows
      frames(500);
      expect_out("R8", 10'b0, M_EXT);
      expect_out("R4", M_DM | M_AZ, M_DM | M_AZ);
      frames(1);
      expect_out("R8", M_EXT, M_EXT);
      frames(3);
      expect_out("R8", M_EXT, M_EXT);
      expect_out("R4", M_DM, M_DM | M_DR);
      frames(1);
      expect_out("R8", 10'b0, M_EXT);
      expect_out("R4", M_DR, M_DM | M_DR);
      expect_out("R3", M_AZ, M_AZ);
      frames(5);
      expect_out("R3", M_AZ, M_AZ | M_AR);
      frames(1);
      expect_out("R3", 10'b0, M_AZ);
      expect_out("R11", M_AR | M_DR, M_AR | M_DR);

      // R6: ADC path power-down, immediate gate, no register reset
      @(negedge clk); adc_pwr_en = 1'b0;
      expect_out("R6", M_AZ | M_DR, M_AZ | M_AR | M_RST | M_DM | M_DR);
      frames(2);
      expect_out("R6", M_AZ, M_AZ | M_AR | M_RST);

      // R10: ADC restart, DAC untouched
      @(negedge clk); adc_pwr_en = 1'b1;
      frames(521);
      expect_out("R10", M_AZ | M_DR, M_AZ | M_DM | M_DR);
      frames(1);
      expect_out("R10", M_AR, M_AZ | M_AR);

      // R7: DAC path power-down forces flags high
      @(negedge clk); zero_det_in = 2'b00; dac_pwr_en = 1'b0;
      expect_out("R7", M_DM | M_ZF, M_DM | M_DR | M_ZF | M_RST);
      expect_out("R10", M_AR, M_AZ | M_AR);
      frames(2);
      @(negedge clk); dac_pwr_en = 1'b1;
      expect_out("R7", 10'b0, M_ZF);
      frames(515);
      expect_out("R10", M_DM, M_DM | M_DR);
      frames(1);
      expect_out("R10", M_DR, M_DM | M_DR);

      // R9: power-down mid-window restarts everything
      @(negedge clk); pdn_n = 1'b0;
      expect_out("R1", V_DOWN, M_ALL);
      wake();
      frames(300);
      @(negedge clk); pdn_n = 1'b0;
      expect_out("R1", V_DOWN, M_ALL);
      wake();
      frames(515);
      expect_out("R9", M_DM | M_AZ | M_EXT, M_DM | M_AZ | M_EXT);
      frames(1);
      expect_out("R9", M_AZ, M_DM | M_AZ | M_EXT);
      frames(5);
      expect_out("R9", M_AZ, M_AZ);
      frames(1);
      expect_out("R9", 10'b0, M_AZ);

      finish_run();
   end

endmodule